// File: doc/BRIEF.md
# Serial Command Shift Interface

This block is the serial front end of a multi-channel DAC controller, modelled entirely in the system-clock domain. It oversamples a four-wire serial port: serial clock, serial data in, an active-low select, and a serial data out. Each input passes through a two-flop synchronizer, and edges are found by comparing each synchronized level with its value one cycle earlier. While the select is low, every rising serial-clock edge shifts one data bit into a 32-bit register, most significant bit first.

When the select returns high, the transfer is complete. The 24 most recently shifted bits are split into a 4-bit command, a 4-bit channel address and a 16-bit data word. These are presented to the downstream decoder together with a one-cycle execute strobe.

Either 24-bit or 32-bit frames are accepted, and longer ones are tolerated. A frame that ends with fewer than 24 captured bits produces an error pulse instead of an execute strobe. The oldest bit of the shift register is sent out on the serial output on falling serial-clock edges, so several such front ends can be chained.

Top module: `ser_cmd_if`

## Requirements
- R1: Serial-clock edges seen while the select is high shift nothing. The register contents, and therefore the serial output stream, continue as if those edges never happened.
- R2: Data is captured on rising serial-clock edges, MSB first. Of the last 24 bits shifted, the first 4 are the command (cmdOut), the next 4 are the address (addrOut) and the final 16 are the data word (dataOut), in MSB-first order within each field.
- R3: In a 32-bit frame, the 8 leading bits have no effect on cmdOut, addrOut or dataOut.
- R4: When the select rises after 24 or more captured bits, execStb is high for exactly one system-clock cycle, and the fields are valid in that same cycle.
- R5: When the select rises after fewer than 24 captured bits (for example 23 or 10), frameErr pulses for one cycle and no execStb is produced.
- R6: After n rising serial-clock edges with the select low, where n ≥ 32, the serial output following the next falling serial-clock edge equals bit number n−32 of the input stream. The stream starts from zeros after reset, and the serial output changes only on falling serial-clock edges.
- R7: The serial output keeps its value while the select is high, including when the serial clock toggles.
- R8: After reset, sdoOut, execStb, frameErr, cmdOut, addrOut and dataOut are all 0.
- R9: A frame longer than 32 bits still decodes its last 24 bits and produces one execStb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sckIn | input | 1 | Serial clock, asynchronous |
| sdiIn | input | 1 | Serial data in, asynchronous |
| csnIn | input | 1 | Active-low select, asynchronous |
| sdoOut | output | 1 | Serial data out for chaining |
| execStb | output | 1 | One-cycle execute strobe |
| frameErr | output | 1 | One-cycle short-frame pulse |
| cmdOut | output | 4 | Decoded command |
| addrOut | output | 4 | Decoded channel address |
| dataOut | output | 16 | Decoded data word |

## Verification
The decoder is exercised with five frame lengths: exactly 24 bits, 32 bits with leading ones, 40 bits, 23 bits and 10 bits. These separate "last 24 bits" decoding from "first 24 bits" decoding, and they probe the error threshold on both sides.

A scoreboard holds the expected command, address and data, or an expected error, for each frame. The serial output is compared after every falling edge against a model of the bit stream that grows across all frames. Bursts of serial clock with the select held high are inserted between frames: if those edges shifted data, the serial output would later disagree with the model.

// File: rtl/ser_cmd_pkg.sv
package ser_cmd_pkg;
  // Strobes from control to datapath, one system-clock cycle each
  typedef struct packed {
    logic shift;   // take one bit from the synchronized data line
    logic sdoUpd;  // falling serial edge: refresh the serial output
    logic latch;   // valid frame end: capture the decoded fields
  } strobe_t;
endpackage

// File: rtl/ser_cmd_sync.sv
module ser_cmd_sync #(
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : gSync
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end
endmodule

// File: rtl/ser_cmd_ctrl.sv
module ser_cmd_ctrl
  import ser_cmd_pkg::*;
#(
  parameter int FRAME_MAX = 32,
  parameter int MIN_BITS  = 24
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sckS,
  input  logic    csnS,
  output strobe_t stb,
  output logic    execStb,
  output logic    frameErr
);
  localparam int CNT_W = $clog2(FRAME_MAX + 1);

  logic             sckD, csnD;
  logic [CNT_W-1:0] bitCnt;
  logic             sckRise, sckFall, csRise, enough;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckD <= 1'b0;
      csnD <= 1'b1;
    end else begin
      sckD <= sckS;
      csnD <= csnS;
    end
  end

  assign sckRise = sckS & ~sckD;
  assign sckFall = ~sckS & sckD;
  assign csRise  = csnS & ~csnD;
  assign enough  = (bitCnt >= CNT_W'(MIN_BITS));

  // Bit counter saturates so over-long frames still decode
  always_ff @(posedge clk) begin
    if (!rstN || csnS)
      bitCnt <= '0;
    else if (sckRise && bitCnt != CNT_W'(FRAME_MAX))
      bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    stb.shift  = sckRise & ~csnS;
    stb.sdoUpd = sckFall;
    stb.latch  = csRise & enough;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      execStb  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      execStb  <= csRise & enough;
      frameErr <= csRise & ~enough;
    end
  end

  // R4
  exec_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    execStb |=> !execStb);
  // R4
  exec_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    execStb |-> $past(bitCnt) >= CNT_W'(MIN_BITS));
  // R5
  err_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> $past(bitCnt) < CNT_W'(MIN_BITS));
  // R5
  exec_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(execStb && frameErr));
endmodule

// File: rtl/ser_cmd_dpath.sv
module ser_cmd_dpath
  import ser_cmd_pkg::*;
#(
  parameter int FRAME_MAX = 32,
  parameter int CMD_W     = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdiS,
  input  strobe_t           stb,
  output logic              sdoOut,
  output logic [CMD_W-1:0]  cmdOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut
);
  localparam int FIELD_W = CMD_W + ADDR_W + DATA_W;

  logic [FRAME_MAX-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN)
      shiftReg <= '0;
    else if (stb.shift)
      shiftReg <= {shiftReg[FRAME_MAX-2:0], sdiS};
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      sdoOut <= 1'b0;
    else if (stb.sdoUpd)
      sdoOut <= shiftReg[FRAME_MAX-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdOut  <= '0;
      addrOut <= '0;
      dataOut <= '0;
    end else if (stb.latch) begin
      cmdOut  <= shiftReg[FIELD_W-1 -: CMD_W];
      addrOut <= shiftReg[DATA_W+ADDR_W-1 -: ADDR_W];
      dataOut <= shiftReg[DATA_W-1:0];
    end
  end

  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.shift |=> $stable(shiftReg));
  // R6
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdoOut) |-> $past(stb.sdoUpd));
  // R4
  field_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latch |=> $stable(dataOut));
endmodule

// File: rtl/ser_cmd_if.sv
module ser_cmd_if
  import ser_cmd_pkg::*;
#(
  parameter int FRAME_MAX = 32,
  parameter int MIN_BITS  = 24,
  parameter int CMD_W     = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              sdiIn,
  input  logic              csnIn,
  output logic              sdoOut,
  output logic              execStb,
  output logic              frameErr,
  output logic [CMD_W-1:0]  cmdOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut
);
  logic [2:0] syncV;
  strobe_t    stb;

  // bit 2: select (idles high), bit 1: data, bit 0: serial clock
  ser_cmd_sync #(.WIDTH(3), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({csnIn, sdiIn, sckIn}),
    .syncOut(syncV)
  );

  ser_cmd_ctrl #(.FRAME_MAX(FRAME_MAX), .MIN_BITS(MIN_BITS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .sckS(syncV[0]), .csnS(syncV[2]),
    .stb(stb), .execStb(execStb), .frameErr(frameErr)
  );

  ser_cmd_dpath #(.FRAME_MAX(FRAME_MAX), .CMD_W(CMD_W),
                  .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN),
    .sdiS(syncV[1]), .stb(stb),
    .sdoOut(sdoOut), .cmdOut(cmdOut), .addrOut(addrOut), .dataOut(dataOut)
  );
endmodule

// File: tb/ser_cmd_if_test.sv
module ser_cmd_if_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, sdiIn = 1'b0, csnIn = 1'b1;
  logic sdoOut, execStb, frameErr;
  logic [3:0]  cmdOut, addrOut;
  logic [15:0] dataOut;

  always #2 clk = ~clk;  // 250 MHz

  ser_cmd_if uut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .sdiIn(sdiIn), .csnIn(csnIn),
    .sdoOut(sdoOut), .execStb(execStb), .frameErr(frameErr),
    .cmdOut(cmdOut), .addrOut(addrOut), .dataOut(dataOut)
  );

  typedef struct {
    bit          isErr;
    logic [3:0]  c;
    logic [3:0]  a;
    logic [15:0] d;
  } exp_t;

  exp_t expQ[$];
  bit   hist[$];  // every bit shifted with the select low
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic bit expSdo();
    if (hist.size() < 32) return 1'b0;
    return hist[hist.size() - 32];
  endfunction

  // Scoreboard monitor: R4, R5, R2, R3, R9
  always @(negedge clk) begin
    if (rstN && (execStb || frameErr)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected strobe", {execStb, frameErr}, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (e.isErr) begin
          check(frameErr && !execStb, "R5 short frame error", {execStb, frameErr}, 2'b01);
        end else begin
          check(execStb && !frameErr, "R4 execute strobe", {execStb, frameErr}, 2'b10);
          check({cmdOut, addrOut, dataOut} == {e.c, e.a, e.d}, "R2 decoded fields",
                {cmdOut, addrOut, dataOut}, {e.c, e.a, e.d});
        end
      end
    end
  end

  // Drives one frame; bit i of the stream is val[n-1-i]
  task automatic sendFrame(input logic [63:0] val, input int n, input string req);
    exp_t e;
    csnIn = 1'b0;
    waitClk(6);
    for (int i = 0; i < n; i++) begin
      sdiIn = val[n-1-i];
      sckIn = 1'b1;
      hist.push_back(val[n-1-i]);
      waitClk(6);
      sckIn = 1'b0;
      waitClk(5);
      check(sdoOut == expSdo(), "R6 serial output delay", sdoOut, expSdo());
      waitClk(1);
    end
    e.isErr = (n < 24);
    e.c = val[23:20];
    e.a = val[19:16];
    e.d = val[15:0];
    expQ.push_back(e);
    csnIn = 1'b1;
    waitClk(12);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  // Serial clock toggles with the select high: R1, R7
  task automatic idleToggle(input int k);
    bit hold;
    hold = sdoOut;
    sdiIn = 1'b1;
    for (int i = 0; i < k; i++) begin
      sckIn = 1'b1;
      waitClk(6);
      sckIn = 1'b0;
      waitClk(5);
      check(sdoOut == hold, "R7 output held while deselected", sdoOut, hold);
      waitClk(1);
    end
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    // R8
    check(sdoOut == 1'b0, "R8 sdo reset", sdoOut, 0);
    check(execStb == 1'b0 && frameErr == 1'b0, "R8 strobes reset", {execStb, frameErr}, 0);
    check({cmdOut, addrOut, dataOut} == 24'h0, "R8 fields reset", {cmdOut, addrOut, dataOut}, 0);

    sendFrame(64'h35A5C3, 24, "R2 24-bit frame decoded");
    sendFrame(64'hFFF21234, 32, "R3 32-bit frame, leading bits ignored");
    idleToggle(4);
    sendFrame(64'h0, 23, "R5 23-bit frame rejected");
    idleToggle(3);
    sendFrame(64'h2A5, 10, "R5 10-bit frame rejected");
    sendFrame(64'hABCD67BEEF, 40, "R9 40-bit frame uses last 24 bits");
    idleToggle(5);
    // R1: stream continues as if the deselected edges never happened
    sendFrame(64'h4C0F0E, 24, "R1 frame after deselected clocks");
    sendFrame(64'hF0000000 | 64'h81FFFF, 32, "R3 second 32-bit frame");

    check(expQ.size() == 0, "R4 all frames accounted", expQ.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule